// File: doc/BRIEF.md
# Set-associative translation buffer

This block caches page table entries so that a virtual page number can be turned into a physical page number without touching the page table. It holds sixteen entries in four sets of four ways. An 8-bit virtual page number is split into a set index and a tag. The four ways of the chosen set are compared against the tag together, and a matching valid way returns its 6-bit physical page number in the same cycle as the request.

On a miss the block raises no hit. An outside translation path then fetches the entry and presents it on the fill port. On the next clock edge the block stores it. The fill goes to a way that already holds the same tag if there is one. Failing that, it goes to the lowest free way. When the set is full, a round-robin pointer kept for each set picks the victim. A flush input drops every mapping in one cycle, for use on an address-space switch.

There is no state machine in the sequential sense. Each fill is classified into one of four named kinds: NONE (no fill this cycle), MATCH (the tag is already present and its way is overwritten), FREE (the lowest invalid way is taken) and EVICT (the set is full, so the way under the set's pointer is replaced and the pointer steps by one). The only register transitions are the valid bit going from clear to set on a fill and from set to clear on a flush, and the pointer stepping on EVICT or clearing on a flush.

Top module: `xlat_cache`

## Requirements
- R1: The set index is bits 1:0 of the virtual page number and the tag is bits 7:2; only the four ways of that set are searched.
- R2: A lookup hits when a valid way of the selected set holds the request tag. lk_hit is then 1 and lk_ppn carries that way's physical page number, combinationally, in the request cycle.
- R3: On a miss lk_hit is 0 and lk_ppn is 0.
- R4: A fill is written at the clock edge that ends its cycle and is seen by lookups from the next cycle onward. A lookup in the same cycle as the fill sees the old contents.
- R5: When the fill tag is absent from the set and at least one way is invalid, the lowest-numbered invalid way receives the entry.
- R6: When the fill tag is absent and all four ways are valid, the way named by that set's 2-bit pointer is replaced. The pointer is 0 after reset and steps by one, wrapping from 3 to 0, only on such an eviction.
- R7: A fill whose tag is already valid in the set overwrites that way's physical page number. It does not take a second way and does not move the pointer, so at most one way of a set ever matches.
- R8: flush_all clears every valid bit and every pointer at the next edge. A fill in the same cycle is dropped.
- R9: After reset every entry is invalid and every lookup misses.
- R10: A fill changes only the selected set. Entries of other sets keep their mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Drop all mappings and reset pointers |
| lk_vpn | input | 8 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup found a valid matching way |
| lk_ppn | output | 6 | Physical page number on a hit, else 0 |
| fill_en | input | 1 | Install an entry this cycle |
| fill_vpn | input | 8 | Virtual page number of the installed entry |
| fill_ppn | input | 6 | Physical page number of the installed entry |

## Verification
The bench fills one set past its capacity and checks which tags survive. A design with a wrong victim choice, a pointer that never wraps, or a pointer that moves on MATCH or FREE fills would lose the wrong mapping and turn a hit into a miss. Refilling an existing tag with a new page number catches a design that duplicates entries, which would return a stale or OR-merged page number. Lookups in the same cycle as a fill, and fills in the same cycle as a flush, catch designs that bypass the write path or let a fill survive a flush. Long random traffic over a small tag space checks the set split and the independence of the sets.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // How a fill request is placed into its set.
    typedef enum logic [1:0] {
        FILL_NONE  = 2'd0,
        FILL_MATCH = 2'd1,
        FILL_FREE  = 2'd2,
        FILL_EVICT = 2'd3
    } fill_kind_e;

endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [PPN_W-1:0]             wr_ppn,
    input  logic [SET_W-1:0]             a_set,
    output logic [WAYS-1:0]              a_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   a_tag,
    output logic [WAYS-1:0][PPN_W-1:0]   a_ppn,
    input  logic [SET_W-1:0]             b_set,
    output logic [WAYS-1:0]              b_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   b_tag
);

    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic sel;
            assign sel = wr_en && !flush
                         && (wr_set == SET_W'(s)) && (wr_way == WAY_W'(w));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[s][w] <= 1'b0;
                end else if (flush) begin
                    valid_q[s][w] <= 1'b0;
                end else if (sel) begin
                    valid_q[s][w] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (sel) begin
                    tag_q[s][w] <= wr_tag;
                    ppn_q[s][w] <= wr_ppn;
                end
            end
        end
    end

    always_comb begin
        a_valid = valid_q[a_set];
        a_tag   = tag_q[a_set];
        a_ppn   = ppn_q[a_set];
        b_valid = valid_q[b_set];
        b_tag   = tag_q[b_set];
    end

    // Without a write or a flush, no valid bit may move.
    p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !flush) |=> $stable(valid_q));

    // A write touches no set other than its own.
    p_other_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && wr_set != SET_W'(0)) |=> $stable(valid_q[0]));

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0][PPN_W-1:0]  ppns,
    input  logic [TAG_W-1:0]            req_tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [PPN_W-1:0]            ppn
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[w] && (tags[w] == req_tag);
    end

    always_comb begin
        ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            ppn = ppn | (ppns[w] & {PPN_W{hit_vec[w]}});
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [SET_W-1:0]   set_sel,
    input  logic [WAYS-1:0]    set_valid,
    input  logic [WAYS-1:0]    set_match,
    output logic [WAY_W-1:0]   way,
    output fill_kind_e         kind
);

    logic [SETS-1:0][WAY_W-1:0] ptr_q;
    logic [WAY_W-1:0]           cur_ptr;
    logic [WAY_W-1:0]           free_way;
    logic [WAY_W-1:0]           match_way;

    assign cur_ptr = ptr_q[set_sel];

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) free_way = WAY_W'(w);
        end
    end

    always_comb begin
        match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (set_match[w]) match_way = WAY_W'(w);
        end
    end

    always_comb begin
        if (!fill_en)          kind = FILL_NONE;
        else if (|set_match)   kind = FILL_MATCH;
        else if (!(&set_valid)) kind = FILL_FREE;
        else                   kind = FILL_EVICT;
    end

    always_comb begin
        unique case (kind)
            FILL_NONE:  way = '0;
            FILL_MATCH: way = match_way;
            FILL_FREE:  way = free_way;
            FILL_EVICT: way = cur_ptr;
            default:    way = '0;
        endcase
    end

    for (genvar s = 0; s < SETS; s++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[s] <= '0;
            end else if (flush) begin
                ptr_q[s] <= '0;
            end else if (kind == FILL_EVICT && set_sel == SET_W'(s)) begin
                ptr_q[s] <= ptr_q[s] + 1'b1;
            end
        end
    end

    // An eviction steps its set's pointer by one.
    p_rr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == FILL_EVICT && !flush) |=>
            ptr_q[$past(set_sel)] == WAY_W'($past(cur_ptr) + 1'b1));

    // Other fills leave the pointer alone.
    p_rr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == FILL_MATCH || kind == FILL_FREE) && !flush) |=>
            ptr_q[$past(set_sel)] == $past(cur_ptr));

    // A free fill lands on an invalid way.
    p_free_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == FILL_FREE) |-> !set_valid[way]);

    // A flush clears every pointer.
    p_ptr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_q == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VPN_W = 8,
    parameter int PPN_W = 6,
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = VPN_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn
);

    logic [SET_W-1:0]            lk_set, fl_set;
    logic [TAG_W-1:0]            lk_tag, fl_tag;
    logic [WAYS-1:0]             lk_valid, fl_valid;
    logic [WAYS-1:0][TAG_W-1:0]  lk_tags, fl_tags;
    logic [WAYS-1:0][PPN_W-1:0]  lk_ppns;
    logic [WAYS-1:0]             lk_hvec, fl_hvec;
    logic                        fl_hit;
    logic [PPN_W-1:0]            fl_ppn_unused;
    logic                        wr_go;
    logic [WAY_W-1:0]            wr_way;
    fill_kind_e                  wr_kind;

    assign lk_set = lk_vpn[SET_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_W];
    assign fl_set = fill_vpn[SET_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:SET_W];
    assign wr_go  = fill_en && !flush_all;

    xlat_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_all),
        .wr_en   (wr_go),
        .wr_set  (fl_set),
        .wr_way  (wr_way),
        .wr_tag  (fl_tag),
        .wr_ppn  (fill_ppn),
        .a_set   (lk_set),
        .a_valid (lk_valid),
        .a_tag   (lk_tags),
        .a_ppn   (lk_ppns),
        .b_set   (fl_set),
        .b_valid (fl_valid),
        .b_tag   (fl_tags)
    );

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_lk_match (
        .valid   (lk_valid),
        .tags    (lk_tags),
        .ppns    (lk_ppns),
        .req_tag (lk_tag),
        .hit_vec (lk_hvec),
        .hit     (lk_hit),
        .ppn     (lk_ppn)
    );

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_fl_match (
        .valid   (fl_valid),
        .tags    (fl_tags),
        .ppns    ('0),
        .req_tag (fl_tag),
        .hit_vec (fl_hvec),
        .hit     (fl_hit),
        .ppn     (fl_ppn_unused)
    );

    xlat_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_all),
        .fill_en   (wr_go),
        .set_sel   (fl_set),
        .set_valid (fl_valid),
        .set_match (fl_hvec),
        .way       (wr_way),
        .kind      (wr_kind)
    );

    // Never two matching ways in the looked-up set.
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hvec));

    // A tag match on the fill side must be classified as an overwrite.
    p_match_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && fl_hit) |-> (wr_kind == FILL_MATCH));

    // A miss drives no page number.
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0));

    // After a flush nothing hits.
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lk_hit);

    // A completed fill is visible on the next lookup of that page.
    p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (lk_vpn != $past(fill_vpn))
                  || (lk_hit && lk_ppn == $past(fill_ppn)));

endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_all = 1'b0;
    logic [7:0] lk_vpn = '0;
    logic       lk_hit;
    logic [5:0] lk_ppn;
    logic       fill_en = 1'b0;
    logic [7:0] fill_vpn = '0;
    logic [5:0] fill_ppn = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit         mv [4][4];
    logic [5:0] mt [4][4];
    logic [5:0] mp [4][4];
    int         mptr [4];

    always #5 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_all (flush_all),
        .lk_vpn    (lk_vpn),
        .lk_hit    (lk_hit),
        .lk_ppn    (lk_ppn),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn)
    );

    function automatic logic [6:0] model_look(input logic [7:0] v);
        int s = int'(v[1:0]);
        for (int w = 0; w < 4; w++) begin
            if (mv[s][w] && mt[s][w] == v[7:2]) return {1'b1, mp[s][w]};
        end
        return 7'd0;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 4; s++) begin
            mptr[s] = 0;
            for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
        end
    endtask

    task automatic model_commit(input logic fe, input logic [7:0] fv,
                                input logic [5:0] fp, input logic fl);
        int s;
        int way;
        if (fl) begin
            model_clear();
        end else if (fe) begin
            s = int'(fv[1:0]);
            way = -1;
            for (int w = 0; w < 4; w++)
                if (way < 0 && mv[s][w] && mt[s][w] == fv[7:2]) way = w;
            for (int w = 0; w < 4; w++)
                if (way < 0 && !mv[s][w]) way = w;
            if (way < 0) begin
                way = mptr[s];
                mptr[s] = (mptr[s] + 1) % 4;
            end
            mv[s][way] = 1'b1;
            mt[s][way] = fv[7:2];
            mp[s][way] = fp;
        end
    endtask

    task automatic check_look(input string req);
        logic [6:0] e;
        e = model_look(lk_vpn);
        checks++;
        if (lk_hit !== e[6] || lk_ppn !== e[5:0]) begin
            errors++;
            $display("FAIL %s vpn=%02h actual hit=%0b ppn=%02h expected hit=%0b ppn=%02h",
                     req, lk_vpn, lk_hit, lk_ppn, e[6], e[5:0]);
        end
    endtask

    task automatic step(input logic [7:0] lv, input logic fe, input logic [7:0] fv,
                        input logic [5:0] fp, input logic fl, input string req);
        @(negedge clk);
        lk_vpn = lv; fill_en = fe; fill_vpn = fv; fill_ppn = fp; flush_all = fl;
        #1;
        check_look(req);
        @(posedge clk);
        model_commit(fe, fv, fp, fl);
    endtask

    function automatic logic [7:0] va(input int tag, input int set);
        return {tag[5:0], set[1:0]};
    endfunction

    // Directed check of a specific expectation, independent of the model.
    task automatic expect_hit(input logic [7:0] v, input logic h, input logic [5:0] p,
                              input string req);
        @(negedge clk);
        lk_vpn = v; fill_en = 1'b0; flush_all = 1'b0;
        #1;
        checks++;
        if (lk_hit !== h || lk_ppn !== (h ? p : 6'd0)) begin
            errors++;
            $display("FAIL %s vpn=%02h actual hit=%0b ppn=%02h expected hit=%0b ppn=%02h",
                     req, v, lk_hit, lk_ppn, h, h ? p : 6'd0);
        end
        @(posedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: empty after reset
        expect_hit(8'h00, 1'b0, 6'd0, "R9 reset empty");
        expect_hit(8'hFF, 1'b0, 6'd0, "R9 reset empty");

        // R1: set/tag split
        step(8'h00, 1'b1, va(1, 1), 6'h11, 1'b0, "R1 fill");
        expect_hit(va(1, 1), 1'b1, 6'h11, "R1 hit same set/tag");
        expect_hit(va(1, 0), 1'b0, 6'd0, "R1 other set same tag");
        expect_hit(va(2, 1), 1'b0, 6'd0, "R3 same set other tag");

        // R4: same-cycle lookup sees old content
        step(va(2, 1), 1'b1, va(2, 1), 6'h22, 1'b0, "R4 same cycle");
        expect_hit(va(2, 1), 1'b1, 6'h22, "R4 next cycle");

        // R5/R6: fill set 2 beyond capacity
        for (int t = 0; t < 4; t++) step(8'h00, 1'b1, va(t, 2), 6'(t + 8), 1'b0, "R5 fill");
        for (int t = 0; t < 4; t++) expect_hit(va(t, 2), 1'b1, 6'(t + 8), "R5 all four held");
        step(8'h00, 1'b1, va(4, 2), 6'h30, 1'b0, "R6 evict");
        expect_hit(va(0, 2), 1'b0, 6'd0, "R6 first victim way0");
        expect_hit(va(1, 2), 1'b1, 6'd9, "R6 way1 kept");
        step(8'h00, 1'b1, va(5, 2), 6'h31, 1'b0, "R6 evict");
        expect_hit(va(1, 2), 1'b0, 6'd0, "R6 second victim way1");
        step(8'h00, 1'b1, va(6, 2), 6'h32, 1'b0, "R6 evict");
        step(8'h00, 1'b1, va(7, 2), 6'h33, 1'b0, "R6 evict");
        step(8'h00, 1'b1, va(8, 2), 6'h34, 1'b0, "R6 wrap");
        expect_hit(va(4, 2), 1'b0, 6'd0, "R6 pointer wraps to way0");
        expect_hit(va(5, 2), 1'b1, 6'h31, "R6 way1 after wrap");
        expect_hit(va(1, 1), 1'b1, 6'h11, "R10 other set untouched");

        // R7: overwrite of existing tag
        step(8'h00, 1'b1, va(9, 3), 6'h0A, 1'b0, "R7 fill");
        step(8'h00, 1'b1, va(9, 3), 6'h0B, 1'b0, "R7 refill");
        expect_hit(va(9, 3), 1'b1, 6'h0B, "R7 new ppn");
        for (int t = 10; t < 13; t++) step(8'h00, 1'b1, va(t, 3), 6'(t), 1'b0, "R7 fill");
        expect_hit(va(9, 3), 1'b1, 6'h0B, "R7 no duplicate way");
        expect_hit(va(12, 3), 1'b1, 6'd12, "R7 fourth way held");

        // R8: flush with a concurrent fill
        step(va(9, 3), 1'b1, va(20, 0), 6'h15, 1'b1, "R8 flush cycle");
        expect_hit(va(20, 0), 1'b0, 6'd0, "R8 concurrent fill dropped");
        expect_hit(va(9, 3), 1'b0, 6'd0, "R8 entry dropped");
        expect_hit(va(5, 2), 1'b0, 6'd0, "R8 entry dropped");
        for (int t = 0; t < 5; t++) step(8'h00, 1'b1, va(t, 2), 6'(t + 40), 1'b0, "R8 refill");
        expect_hit(va(0, 2), 1'b0, 6'd0, "R8 pointer reset to way0");
        expect_hit(va(1, 2), 1'b1, 6'd41, "R8 way1 kept");

        // Random traffic against the model: R2, R3, R10
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] lv, fv;
            logic fe, fl;
            lv = {3'b000, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
            fv = {3'b000, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
            fe = ($urandom_range(0, 99) < 40);
            fl = ($urandom_range(0, 999) < 15);
            step(lv, fe, fv, 6'($urandom_range(0, 63)), fl, "R2 R3 R10 random");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule